// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block collects a set of interrupt inputs and presents them to a processor as one active-low request line. Each source has an enable, a priority, a choice between edge and level triggering, and a register holding the address of its service routine. When the processor takes the request, it reads the vector register. That single read acknowledges the winning source, returns its handler address and drops the request line.

Preemption is governed by a hardware stack of priority levels. While a routine is in service, the line is raised again only for a source whose priority is strictly above the level now in service. A write to the end-of-interrupt register retires the innermost routine and restores the level beneath it. That write may raise the line again for a source that was held back.

Sources are sampled through a synchronizer. An edge-triggered source latches a pending flag on a rising edge, and acknowledgement clears that flag. A level-sensitive source is pending for as long as its input is high.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, the status register reports an empty stack, and every configuration and handler register reads 0.
- R2: Word addresses: source i configuration at i, with enable at bit 0, edge mode at bit 1 (1 = edge) and priority at bits 6:4; source i handler address at 0x20+i; vector at 0x40; end-of-interrupt at 0x41; pending bits at 0x42; status at 0x43. Configuration and handler registers read back what was written.
- R3: A vector read returns the handler address of the pending, enabled source with the highest priority. On equal priority, the lowest-numbered source wins.
- R4: A vector read that acknowledges a source leaves `irq_n` at 1 in the following cycle.
- R5: Acknowledgement pushes the priority and number of the source onto the level stack. Status reports the top entry, with the source number in bits 7:0, the level in bits 10:8 and the empty flag in bit 16. Nesting reaches one entry per priority level.
- R6: An edge-triggered source becomes pending on a rising edge of its synchronized input and is cleared by its own acknowledgement. A new edge that arrives in the acknowledging cycle keeps it pending.
- R7: A level-sensitive source stays pending while its input is high, even after acknowledgement, and stops being pending once its input falls.
- R8: `irq_n` is driven low only for a pending, enabled source whose priority is strictly higher than the level in service, or for any such source when the stack is empty. A disabled source never drives it low.
- R9: An end-of-interrupt write pops the stack and restores the previous level. In the next cycle `irq_n` reflects the sources against that restored level.
- R10: A vector read with no qualifying source returns 0 and changes nothing. An end-of-interrupt write to an empty stack is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src | input | N_SRC | Interrupt source inputs, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid combinationally during the read cycle |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
Acknowledgement clears an edge source's pending flag, and the same edge of the clock may also record a fresh rising edge from that source. These two functions can therefore fall in the same cycle. The bench drops a pending edge source and then raises it again, timed so that its synchronized rise lands exactly on the clock edge of the vector read. Afterwards it checks that the pending register still shows the source, and that the source is presented again once its own level is retired.

// File: rtl/nest_irq_pkg.sv
package nest_irq_pkg;
   // register word addresses
   localparam int unsigned ADR_CFG_BASE = 32'h00;
   localparam int unsigned ADR_HND_BASE = 32'h20;
   localparam int unsigned ADR_VEC      = 32'h40;
   localparam int unsigned ADR_EOI      = 32'h41;
   localparam int unsigned ADR_PEND     = 32'h42;
   localparam int unsigned ADR_STAT     = 32'h43;
   // configuration word fields
   localparam int unsigned CFG_EN_BIT   = 0;
   localparam int unsigned CFG_EDGE_BIT = 1;
   localparam int unsigned CFG_PRIO_LSB = 4;
   // status word fields
   localparam int unsigned STAT_LVL_LSB   = 8;
   localparam int unsigned STAT_EMPTY_BIT = 16;
   localparam int unsigned MAX_SRC        = 32;
endpackage

// File: rtl/nic_src_cell.sv
module nic_src_cell #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_in,
   input  logic edge_mode,
   input  logic ack_clr,
   output logic pending
);
   logic synced;
   logic synced_d;
   logic edge_flag;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign synced = src_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= src_in;
               for (int k = 1; k < int'(SYNC_STAGES); k++) begin
                  chain[k] <= chain[k-1];
               end
            end
         end
         assign synced = chain[SYNC_STAGES-1];
      end
   endgenerate

   wire rise = synced & ~synced_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         synced_d  <= 1'b0;
         edge_flag <= 1'b0;
      end else begin
         synced_d <= synced;
         if (!edge_mode)     edge_flag <= 1'b0;
         else if (rise)      edge_flag <= 1'b1;   // new edge beats the clear
         else if (ack_clr)   edge_flag <= 1'b0;
      end
   end

   assign pending = edge_mode ? edge_flag : synced;
endmodule

// File: rtl/nic_prio_arb.sv
module nic_prio_arb #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned SRC_W  = 5
) (
   input  logic [N_SRC-1:0]             req,
   input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
   output logic                         any,
   output logic [SRC_W-1:0]             win_idx,
   output logic [PRIO_W-1:0]            win_prio
);
   always_comb begin
      any      = 1'b0;
      win_idx  = '0;
      win_prio = '0;
      // strict compare keeps the lowest index on a tie
      for (int i = 0; i < int'(N_SRC); i++) begin
         if (req[i] && (!any || prio[i] > win_prio)) begin
            any      = 1'b1;
            win_idx  = SRC_W'(i);
            win_prio = prio[i];
         end
      end
   end
endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned SRC_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_lvl,
   input  logic [SRC_W-1:0]  push_src,
   output logic              empty,
   output logic              full,
   output logic [PRIO_W-1:0] top_lvl,
   output logic [SRC_W-1:0]  top_src,
   output logic [PRIO_W-1:0] under_lvl,
   output logic              under_ok
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [CNT_W-1:0]  cnt;
   logic [PRIO_W-1:0] lvl_mem [DEPTH];
   logic [SRC_W-1:0]  src_mem [DEPTH];

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_W'(DEPTH));

   wire do_push = push && !full;
   wire do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (do_push) cnt <= cnt + CNT_W'(1);
      else if (do_pop)  cnt <= cnt - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         lvl_mem[IDX_W'(cnt)] <= push_lvl;
         src_mem[IDX_W'(cnt)] <= push_src;
      end
   end

   always_comb begin
      top_lvl   = '0;
      top_src   = '0;
      under_lvl = '0;
      under_ok  = 1'b0;
      if (!empty) begin
         top_lvl = lvl_mem[IDX_W'(cnt - CNT_W'(1))];
         top_src = src_mem[IDX_W'(cnt - CNT_W'(1))];
      end
      if (cnt >= CNT_W'(2)) begin
         under_lvl = lvl_mem[IDX_W'(cnt - CNT_W'(2))];
         under_ok  = 1'b1;
      end
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nest_irq_pkg::*;
#(
   parameter int unsigned N_SRC       = 32,
   parameter int unsigned PRIO_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  irq_src,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_n
);
   localparam int unsigned SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
   localparam int unsigned DEPTH = 1 << PRIO_W;

   // elaboration-time parameter checks
   generate
      if (N_SRC < 1 || N_SRC > MAX_SRC) begin : g_bad_nsrc
         $error("N_SRC must be 1..32");
      end
      if (PRIO_W < 1 || PRIO_W > 3) begin : g_bad_prio
         $error("PRIO_W must be 1..3 to fit the field layout");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (DATA_W < 17 || DATA_W < N_SRC) begin : g_bad_data
         $error("DATA_W too small for status or pending words");
      end
   endgenerate

   // ---------------- bus decode ----------------
   wire is_rd   = bus_sel && !bus_wr;
   wire is_wr   = bus_sel && bus_wr;
   wire vec_hit = (bus_addr == ADDR_W'(ADR_VEC));
   wire eoi_hit = (bus_addr == ADDR_W'(ADR_EOI));

   // ---------------- per-source state ----------------
   logic [N_SRC-1:0]             en_q;
   logic [N_SRC-1:0]             edge_q;
   logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
   logic [DATA_W-1:0]            hnd_q [N_SRC];
   logic [N_SRC-1:0]             pend;

   logic              win_any;
   logic [SRC_W-1:0]  win_idx;
   logic [PRIO_W-1:0] win_prio;
   logic              ack;
   logic              eoi;

   generate
      for (genvar g = 0; g < int'(N_SRC); g++) begin : g_src
         logic              en_r;
         logic              edge_r;
         logic [PRIO_W-1:0] prio_r;
         logic [DATA_W-1:0] hnd_r;

         wire cfg_wr = is_wr && (bus_addr == ADDR_W'(ADR_CFG_BASE + g));
         wire hnd_wr = is_wr && (bus_addr == ADDR_W'(ADR_HND_BASE + g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_r   <= 1'b0;
               edge_r <= 1'b0;
               prio_r <= '0;
               hnd_r  <= '0;
            end else begin
               if (cfg_wr) begin
                  en_r   <= bus_wdata[CFG_EN_BIT];
                  edge_r <= bus_wdata[CFG_EDGE_BIT];
                  prio_r <= bus_wdata[CFG_PRIO_LSB +: PRIO_W];
               end
               if (hnd_wr) hnd_r <= bus_wdata;
            end
         end

         assign en_q[g]   = en_r;
         assign edge_q[g] = edge_r;
         assign prio_q[g] = prio_r;
         assign hnd_q[g]  = hnd_r;

         nic_src_cell #(
            .SYNC_STAGES(SYNC_STAGES)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_in   (irq_src[g]),
            .edge_mode(edge_r),
            .ack_clr  (ack && (win_idx == SRC_W'(g))),
            .pending  (pend[g])
         );
      end
   endgenerate

   // ---------------- arbitration ----------------
   nic_prio_arb #(
      .N_SRC (N_SRC),
      .PRIO_W(PRIO_W),
      .SRC_W (SRC_W)
   ) u_arb (
      .req     (pend & en_q),
      .prio    (prio_q),
      .any     (win_any),
      .win_idx (win_idx),
      .win_prio(win_prio)
   );

   // ---------------- level stack ----------------
   logic              stk_empty;
   logic              stk_full;
   logic [PRIO_W-1:0] stk_lvl;
   logic [SRC_W-1:0]  stk_src;
   logic [PRIO_W-1:0] stk_under_lvl;
   logic              stk_under_ok;

   wire req_ok = win_any && (stk_empty || (win_prio > stk_lvl));
   assign ack  = is_rd && vec_hit && req_ok;
   assign eoi  = is_wr && eoi_hit;

   nic_level_stack #(
      .DEPTH (DEPTH),
      .PRIO_W(PRIO_W),
      .SRC_W (SRC_W)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ack),
      .pop      (eoi),
      .push_lvl (win_prio),
      .push_src (win_idx),
      .empty    (stk_empty),
      .full     (stk_full),
      .top_lvl  (stk_lvl),
      .top_src  (stk_src),
      .under_lvl(stk_under_lvl),
      .under_ok (stk_under_ok)
   );

   // ---------------- request line ----------------
   logic              empty_nx;
   logic [PRIO_W-1:0] lvl_nx;
   logic              raise;
   logic              irq_q;

   always_comb begin
      empty_nx = stk_empty;
      lvl_nx   = stk_lvl;
      if (eoi && !stk_empty) begin
         empty_nx = !stk_under_ok;
         lvl_nx   = stk_under_lvl;
      end
      raise = win_any && (empty_nx || (win_prio > lvl_nx));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (ack) irq_q <= 1'b0;
      else          irq_q <= raise;
   end

   assign irq_n = !irq_q;

   // ---------------- read data ----------------
   always_comb begin
      bus_rdata = '0;
      if (is_rd) begin
         if (vec_hit) begin
            if (req_ok) bus_rdata = hnd_q[win_idx];
         end else if (bus_addr == ADDR_W'(ADR_PEND)) begin
            bus_rdata[N_SRC-1:0] = pend;
         end else if (bus_addr == ADDR_W'(ADR_STAT)) begin
            bus_rdata[SRC_W-1:0]                 = stk_src;
            bus_rdata[STAT_LVL_LSB +: PRIO_W]    = stk_lvl;
            bus_rdata[STAT_EMPTY_BIT]            = stk_empty;
         end else begin
            for (int i = 0; i < int'(N_SRC); i++) begin
               if (bus_addr == ADDR_W'(ADR_CFG_BASE + i)) begin
                  bus_rdata[CFG_EN_BIT]                = en_q[i];
                  bus_rdata[CFG_EDGE_BIT]              = edge_q[i];
                  bus_rdata[CFG_PRIO_LSB +: PRIO_W]    = prio_q[i];
               end
               if (bus_addr == ADDR_W'(ADR_HND_BASE + i)) begin
                  bus_rdata = hnd_q[i];
               end
            end
         end
      end
   end
endmodule

// File: rtl/nest_irq_chk.sv
module nest_irq_chk #(
   parameter int unsigned PRIO_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_n,
   input logic              ack,
   input logic              eoi,
   input logic              req_ok,
   input logic              stk_empty,
   input logic              stk_full,
   input logic [PRIO_W-1:0] stk_lvl,
   input logic [PRIO_W-1:0] win_prio
);
   // R4: acknowledgement drops the request line
   a_r4_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> irq_n);

   // R5: acknowledgement never meets a full stack
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !stk_full);

   // R5: pushed level appears on top
   a_r5_push_top: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!stk_empty && stk_lvl == $past(win_prio)));

   // R8: nested acknowledgement only for strictly higher priority
   a_r8_strict_nest: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !stk_empty) |-> (win_prio > stk_lvl));

   // R9: a qualifying source with no bus operation asserts the line
   a_r9_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack && !eoi && req_ok) |=> !irq_n);

   // R10: end-of-interrupt on an empty stack leaves it empty
   a_r10_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && stk_empty) |=> stk_empty);
endmodule

bind nest_irq_ctrl nest_irq_chk #(
   .PRIO_W(PRIO_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_n    (irq_n),
   .ack      (ack),
   .eoi      (eoi),
   .req_ok   (req_ok),
   .stk_empty(stk_empty),
   .stk_full (stk_full),
   .stk_lvl  (stk_lvl),
   .win_prio (win_prio)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
   localparam int NS = 8;
   localparam logic [7:0] A_VEC = 8'h40, A_EOI = 8'h41, A_PEND = 8'h42, A_STAT = 8'h43;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] src = '0;
   logic          sel = 1'b0;
   logic          wen = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq_n;

   always #2.5 clk = ~clk;

   nest_irq_ctrl #(
      .N_SRC(NS), .PRIO_W(3), .SYNC_STAGES(2), .ADDR_W(8), .DATA_W(32)
   ) uut (
      .clk(clk), .rst_n(rst_n), .irq_src(src), .bus_sel(sel), .bus_wr(wen),
      .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bwr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wen = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wen = 1'b0;
   endtask

   task automatic brd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wen = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   function automatic logic [31:0] cfgw(input bit en, input bit edg, input int pr);
      return (32'(pr) << 4) | (32'(edg) << 1) | 32'(en);
   endfunction

   function automatic logic [31:0] hnd(input int i);
      return 32'h1000 + 32'(i) * 32'h10;
   endfunction

   function automatic logic [31:0] stat(input int s, input int lvl);
      return (32'(lvl) << 8) | 32'(s);
   endfunction

   function automatic int sweep_prio(input int i);
      return (3 * i) % 4;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      idle(4);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      chk("R1 irq_n", {31'b0, irq_n}, 32'h1);
      brd(A_STAT, v); chk("R1 status empty", v, 32'h0001_0000);
      brd(8'h03, v);  chk("R1 cfg zero", v, 32'h0);
      brd(8'h23, v);  chk("R1 handler zero", v, 32'h0);

      // R2: program and read back
      for (int i = 0; i < NS; i++) begin
         bwr(8'(32'h20 + i), hnd(i));
         bwr(8'(i), cfgw(1, 1, sweep_prio(i)));
      end
      for (int i = 0; i < NS; i++) begin
         brd(8'(i), v);          chk("R2 cfg readback", v, cfgw(1, 1, sweep_prio(i)));
         brd(8'(32'h20 + i), v); chk("R2 handler readback", v, hnd(i));
      end

      // R3/R4/R6/R9: every pair of edge sources
      for (int a = 0; a < NS; a++) begin
         for (int b = a + 1; b < NS; b++) begin
            int first, second;
            first  = (sweep_prio(b) > sweep_prio(a)) ? b : a;
            second = (first == a) ? b : a;
            @(negedge clk); src[a] = 1'b1; src[b] = 1'b1;
            idle(5);
            chk("R8 irq asserted", {31'b0, irq_n}, 32'h0);
            brd(A_VEC, v); chk("R3 winner vector", v, hnd(first));
            chk("R4 irq dropped", {31'b0, irq_n}, 32'h1);
            brd(A_PEND, v); chk("R6 winner cleared", v, 32'h1 << second);
            brd(A_STAT, v); chk("R5 status top", v, stat(first, sweep_prio(first)));
            bwr(A_EOI, 32'h0);
            chk("R9 reassert after pop", {31'b0, irq_n}, 32'h0);
            brd(A_VEC, v); chk("R3 second vector", v, hnd(second));
            bwr(A_EOI, 32'h0);
            chk("R9 idle after pop", {31'b0, irq_n}, 32'h1);
            brd(A_PEND, v); chk("R6 all cleared", v, 32'h0);
            @(negedge clk); src = '0;
            idle(4);
         end
      end

      // R5: nest through every priority level
      for (int i = 0; i < NS; i++) bwr(8'(i), cfgw(1, 1, i));
      for (int k = 0; k < NS; k++) begin
         @(negedge clk); src[k] = 1'b1;
         idle(5);
         chk("R8 higher level preempts", {31'b0, irq_n}, 32'h0);
         brd(A_VEC, v);  chk("R3 nested vector", v, hnd(k));
         brd(A_STAT, v); chk("R5 nested top", v, stat(k, k));
      end
      for (int k = NS - 1; k >= 0; k--) begin
         bwr(A_EOI, 32'h0);
         brd(A_STAT, v);
         chk("R9 restored level", v, (k > 0) ? stat(k - 1, k - 1) : 32'h0001_0000);
         chk("R9 no request", {31'b0, irq_n}, 32'h1);
      end
      @(negedge clk); src = '0;
      idle(4);

      // R8/R9: equal priority waits, higher preempts, release in order
      for (int i = 0; i < NS; i++) bwr(8'(i), 32'h0);
      bwr(8'h00, cfgw(1, 1, 1));
      bwr(8'h01, cfgw(1, 1, 1));
      bwr(8'h02, cfgw(1, 1, 5));
      @(negedge clk); src[0] = 1'b1;
      idle(5);
      brd(A_VEC, v); chk("R3 base vector", v, hnd(0));
      @(negedge clk); src[1] = 1'b1;
      idle(5);
      chk("R8 equal priority held", {31'b0, irq_n}, 32'h1);
      @(negedge clk); src[2] = 1'b1;
      idle(5);
      chk("R8 higher priority asserts", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v);  chk("R3 preempt vector", v, hnd(2));
      brd(A_STAT, v); chk("R5 preempt top", v, stat(2, 5));
      bwr(A_EOI, 32'h0);
      chk("R9 equal still held", {31'b0, irq_n}, 32'h1);
      brd(A_STAT, v); chk("R9 level back to 1", v, stat(0, 1));
      bwr(A_EOI, 32'h0);
      chk("R9 held source released", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v); chk("R3 held vector", v, hnd(1));
      bwr(A_EOI, 32'h0);
      chk("R9 quiet", {31'b0, irq_n}, 32'h1);
      @(negedge clk); src = '0;
      idle(4);

      // R7: level-sensitive source
      bwr(8'h03, cfgw(1, 0, 5));
      @(negedge clk); src[3] = 1'b1;
      idle(5);
      chk("R7 level asserts", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v); chk("R7 level vector", v, hnd(3));
      chk("R4 level ack drops", {31'b0, irq_n}, 32'h1);
      brd(A_PEND, v); chk("R7 not cleared by ack", v, 32'h8);
      bwr(A_EOI, 32'h0);
      chk("R7 reasserts while high", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v); chk("R7 second vector", v, hnd(3));
      @(negedge clk); src[3] = 1'b0;
      idle(4);
      bwr(A_EOI, 32'h0);
      chk("R7 quiet after fall", {31'b0, irq_n}, 32'h1);
      brd(A_PEND, v); chk("R7 pending follows input", v, 32'h0);

      // R8/R10: disabled source
      bwr(8'h05, cfgw(0, 1, 7));
      @(negedge clk); src[5] = 1'b1;
      idle(5);
      chk("R8 disabled no request", {31'b0, irq_n}, 32'h1);
      brd(A_PEND, v); chk("R8 disabled still pending", v, 32'h20);
      brd(A_VEC, v);  chk("R10 empty vector read", v, 32'h0);
      brd(A_STAT, v); chk("R10 stack untouched", v, 32'h0001_0000);
      bwr(8'h05, cfgw(1, 1, 7));
      idle(1);
      chk("R8 enable asserts", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v); chk("R3 enabled vector", v, hnd(5));
      bwr(A_EOI, 32'h0);
      @(negedge clk); src[5] = 1'b0;
      idle(4);
      bwr(A_EOI, 32'h0);
      brd(A_STAT, v); chk("R10 pop on empty ignored", v, 32'h0001_0000);
      chk("R10 irq stays high", {31'b0, irq_n}, 32'h1);

      // R6: new edge in the acknowledging cycle
      bwr(8'h06, cfgw(1, 1, 2));
      @(negedge clk); src[6] = 1'b1;
      idle(5);
      @(negedge clk); src[6] = 1'b0;
      idle(4);
      @(negedge clk); src[6] = 1'b1;     // synchronized rise meets the read edge
      @(negedge clk);
      brd(A_VEC, v);  chk("R6 collision vector", v, hnd(6));
      brd(A_PEND, v); chk("R6 new edge kept pending", v, 32'h40);
      chk("R8 same level held", {31'b0, irq_n}, 32'h1);
      bwr(A_EOI, 32'h0);
      chk("R9 collision reasserts", {31'b0, irq_n}, 32'h0);
      brd(A_VEC, v); chk("R6 second service", v, hnd(6));
      bwr(A_EOI, 32'h0);
      brd(A_PEND, v); chk("R6 finally clear", v, 32'h0);
      @(negedge clk); src = '0;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule